// File: doc/BRIEF.md
# Transposing Memory Read Address Generator

This block walks a region of external memory and issues one read request per block. The memory's returned words come back through a read FIFO. The block moves those words onto a ready/valid output stream.

There are two ways to walk the region:

- **Linear mode.** Each request address is one block past the one before it.
- **Transpose mode.** The address steps by a programmable row stride, once for each configured row. It then goes back to the start of the current column, advances by one block, and repeats the stride pattern. An image stored row by row therefore comes out column by column, which rotates it by 90 degrees. For example, a 750-byte by 480-row picture would use a stride of 750, a row field of 479 and a byte count of 360000.

Software supplies the following settings:

- the start address;
- the total byte count;
- a packed jump word;
- a block-size code;
- loop, jump-enable and run flags.

The request address output is the current read address counter and can be read back.

A transfer starts on a rising edge of the run flag. It ends once the bytes requested cover the byte count, unless loop mode restarts it from the start address. In transpose mode each request is a single beat of one data word. A synthesis parameter can reverse the byte order of every output word.

Top module: `trd_reader`

## Requirements
- R1: After reset, rd_done is 1, mem_req is 0 and out_valid is 0.
- R2: In linear mode the k-th request address is start + k*B. B is the block size in bytes: DW/8 for code 0, and 8 shifted left by the code for codes 1 to 5. mem_size always shows the block-size code.
- R3: With jump enabled, cfg_jump_word bits 31:16 give the stride S and bits 15:0 give the row count minus one (N-1). The k-th request address is start + (k mod N)*S + (k div N)*B.
- R4: While mem_req is high and mem_ack is low, mem_addr does not change.
- R5: The transfer issues ceil(count/B) requests and then stops. rd_done is 0 while the transfer runs and becomes 1 after the last request of a non-looping transfer.
- R6: With cfg_loop set, the request after the last one of a pass goes back to the start address with column and row reset, and rd_done stays 0.
- R7: With cfg_jump_en low, cfg_jump_word has no effect and addresses follow R2.
- R8: With code 0, an output word offered while out_ready is low stays on out_data with out_valid high until it is accepted.
- R9: With a nonzero code, out_ready is ignored and each word taken from the FIFO is shown for one cycle with out_valid high.
- R10: No request is raised while the output holding register is full and cannot drain. rd_fifo_pop is high only when the FIFO is not empty and the holding register can take a word.
- R11: Words appear on out_data in FIFO order. With the swap parameter at its default of 0 they are unchanged.
- R12: cfg_run low stops new requests. A new transfer needs a fresh rising edge of cfg_run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | AW | First byte address of the region |
| cfg_byte_count | input | CW | Total bytes to request per pass |
| cfg_jump_word | input | 32 | Stride in bits 31:16, rows minus one in bits 15:0 |
| cfg_blk_code | input | 4 | Block-size code |
| cfg_loop | input | 1 | Restart at the start address after each pass |
| cfg_jump_en | input | 1 | Selects transpose mode |
| cfg_run | input | 1 | Rising edge starts; low stops |
| mem_req | output | 1 | Read request to the memory controller |
| mem_ack | input | 1 | Request accepted |
| mem_addr | output | AW | Request address and current address counter |
| mem_size | output | 4 | Block-size code of the request |
| rd_fifo_data | input | DW | Head word of the memory read FIFO |
| rd_fifo_empty | input | 1 | Read FIFO empty |
| rd_fifo_pop | output | 1 | Take the head word from the read FIFO |
| out_data | output | DW | Output stream word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word (used with code 0 only) |
| rd_done | output | 1 | Non-looping transfer finished |

## Verification
Two events can fall in the same handshake. In transpose mode the last row of the last column wraps to the next column, and at that same moment the byte count completes the pass. The loop restart must take precedence over the column advance.

The looping test drives a two-row, two-column walk through three passes. The scoreboard predicts every request address from the closed formula in R3, taken modulo the pass length. A wrong precedence would put a column-advanced address where the start address is due.

A second pairing is a FIFO pop and a stall on the holding register. With out_ready held low, the bench checks that requests stop and the offered word stays put. After release, every word must arrive in order with none lost or repeated.

// File: rtl/trd_pkg.sv
package trd_pkg;
  // Bytes moved by one request for a given block-size code.
  function automatic logic [31:0] blk_bytes(input logic [3:0] code, input int unsigned bw);
    if (code == 4'd0) return 32'(bw);
    return 32'd8 << code;
  endfunction

  // Address after a stride step in the current column.
  function automatic logic [31:0] stride_next(input logic [31:0] a, input logic [15:0] s);
    return a + {16'd0, s};
  endfunction

  // True when the bytes already issued plus this block cover the count.
  function automatic logic pass_covers(input logic [31:0] issued, input logic [31:0] blk,
                                       input logic [31:0] count);
    return ({1'b0, issued} + {1'b0, blk}) >= {1'b0, count};
  endfunction
endpackage

// File: rtl/trd_walker.sv
module trd_walker #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          loop_en,
  input  logic          jump_en,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_count,
  input  logic [15:0]   stride,
  input  logic [15:0]   rows_m1,
  input  logic [3:0]    code,
  input  logic          hold,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic          hs,
  output logic          jump_step,
  output logic          pass_end
);
  logic          active, run_q;
  logic [AW-1:0] addr, col_base;
  logic [15:0]   row;
  logic [CW-1:0] issued;
  logic [31:0]   blk;
  logic          col_wrap;

  assign blk       = trd_pkg::blk_bytes(code, BW);
  assign mem_req   = active && !hold;
  assign mem_addr  = addr;
  assign hs        = mem_req && mem_ack;
  assign pass_end  = hs && trd_pkg::pass_covers(32'(issued), blk, 32'(byte_count));
  assign col_wrap  = jump_en && (row == rows_m1);
  assign jump_step = hs && !pass_end && jump_en && !col_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      run_q    <= 1'b0;
      addr     <= '0;
      col_base <= '0;
      row      <= '0;
      issued   <= '0;
      done     <= 1'b1;
    end else begin
      run_q <= run;
      if (run && !run_q) begin
        active   <= 1'b1;
        done     <= 1'b0;
        addr     <= start_addr;
        col_base <= start_addr;
        row      <= '0;
        issued   <= '0;
      end else begin
        if (pass_end) begin
          // Loop restart takes precedence over any column wrap.
          addr     <= start_addr;
          col_base <= start_addr;
          row      <= '0;
          issued   <= '0;
          if (!loop_en) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else if (hs) begin
          issued <= issued + CW'(blk);
          if (!jump_en) begin
            addr <= addr + AW'(blk);
          end else if (col_wrap) begin
            row      <= '0;
            col_base <= col_base + AW'(blk);
            addr     <= col_base + AW'(blk);
          end else begin
            row  <= row + 16'd1;
            addr <= AW'(trd_pkg::stride_next(32'(addr), stride));
          end
        end
        if (!run) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trd_outbuf.sv
module trd_outbuf #(
  parameter int DW   = 32,
  parameter bit SWAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_empty,
  input  logic          out_ready,
  input  logic          throttle,
  output logic          fifo_pop,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          full
);
  localparam int BW = DW / 8;
  logic [DW-1:0] word_in;
  logic          drain;

  generate
    if (SWAP) begin : g_swap
      for (genvar i = 0; i < BW; i++) begin : g_byte
        assign word_in[8*i +: 8] = fifo_data[8*(BW-1-i) +: 8];
      end
    end else begin : g_pass
      assign word_in = fifo_data;
    end
  endgenerate

  assign drain    = out_valid && (out_ready || !throttle);
  assign fifo_pop = !fifo_empty && (!out_valid || drain);
  assign full     = out_valid && !drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fifo_pop) begin
      out_valid <= 1'b1;
      out_data  <= word_in;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trd_reader.sv
module trd_reader #(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int DW   = 32,
  parameter bit SWAP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [CW-1:0] cfg_byte_count,
  input  logic [31:0]   cfg_jump_word,
  input  logic [3:0]    cfg_blk_code,
  input  logic          cfg_loop,
  input  logic          cfg_jump_en,
  input  logic          cfg_run,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_size,
  input  logic [DW-1:0] rd_fifo_data,
  input  logic          rd_fifo_empty,
  output logic          rd_fifo_pop,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          rd_done
);
  localparam int BW = DW / 8;
  logic        buf_full, hs, jump_step, pass_end;
  logic [15:0] stride, rows_m1;

  assign stride   = cfg_jump_word[31:16];
  assign rows_m1  = cfg_jump_word[15:0];
  assign mem_size = cfg_blk_code;

  trd_walker #(.AW(AW), .CW(CW), .BW(BW)) u_walk (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .loop_en(cfg_loop),
    .jump_en(cfg_jump_en), .start_addr(cfg_start_addr), .byte_count(cfg_byte_count),
    .stride(stride), .rows_m1(rows_m1), .code(cfg_blk_code), .hold(buf_full),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr), .done(rd_done),
    .hs(hs), .jump_step(jump_step), .pass_end(pass_end)
  );

  trd_outbuf #(.DW(DW), .SWAP(SWAP)) u_obuf (
    .clk(clk), .rst_n(rst_n), .fifo_data(rd_fifo_data), .fifo_empty(rd_fifo_empty),
    .out_ready(out_ready), .throttle(cfg_blk_code == 4'd0), .fifo_pop(rd_fifo_pop),
    .out_data(out_data), .out_valid(out_valid), .full(buf_full)
  );
endmodule

// File: rtl/trd_reader_chk.sv
module trd_reader_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [3:0]    code,
  input logic          rd_fifo_pop,
  input logic          rd_fifo_empty,
  input logic          buf_full,
  input logic          jump_step,
  input logic          pass_end,
  input logic [15:0]   stride,
  input logic          rd_done,
  input logic          loop_en
);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !mem_req || $stable(mem_addr));

  assert_throttle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code == 4'd0 && out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fifo_pop |-> !rd_fifo_empty);

  assert_no_req_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !mem_req);

  assert_stride_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jump_step |=> mem_addr == $past(mem_addr) + AW'($past(stride)));

  assert_busy_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rd_done);

  assert_loop_done_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end && loop_en |=> !rd_done);
endmodule

bind trd_reader trd_reader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .code(cfg_blk_code),
  .rd_fifo_pop(rd_fifo_pop), .rd_fifo_empty(rd_fifo_empty), .buf_full(buf_full),
  .jump_step(jump_step), .pass_end(pass_end), .stride(stride), .rd_done(rd_done),
  .loop_en(cfg_loop)
);

// File: tb/trd_reader_tb.sv
module trd_reader_tb;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] cfg_start_addr = 0, cfg_byte_count = 0, cfg_jump_word = 0;
  logic [3:0]  cfg_blk_code = 0;
  logic        cfg_loop = 0, cfg_jump_en = 0, cfg_run = 0;
  logic        mem_req, mem_ack, rd_fifo_pop, out_valid, rd_done;
  logic        out_ready = 1'b1;
  logic [31:0] mem_addr, out_data;
  logic [DW-1:0] rd_fifo_data = 0;
  logic        rd_fifo_empty = 1'b1;
  logic [3:0]  mem_size;

  int   errors = 0, checks = 0, acks_left = 0, cyc = 0;
  bit   ack_gap = 0, rdy_toggle = 0, ack_allow = 0;
  logic [31:0] memq[$], exp_addr[$], exp_data[$];

  assign mem_ack = mem_req && ack_allow;

  trd_reader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr), .cfg_byte_count(cfg_byte_count),
    .cfg_jump_word(cfg_jump_word), .cfg_blk_code(cfg_blk_code), .cfg_loop(cfg_loop),
    .cfg_jump_en(cfg_jump_en), .cfg_run(cfg_run), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_size(mem_size), .rd_fifo_data(rd_fifo_data),
    .rd_fifo_empty(rd_fifo_empty), .rd_fifo_pop(rd_fifo_pop), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .rd_done(rd_done)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a, input int b);
    return (a + 32'(b * 4)) ^ 32'h5A00_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard driver: expected request addresses and output words.
  task automatic push_expect(input logic [31:0] start, input int nreq, input int blk, input int beats,
                             input bit jmp, input int stride, input int rows, input int passes);
    for (int p = 0; p < passes; p++)
      for (int k = 0; k < nreq; k++) begin
        logic [31:0] a;
        a = jmp ? start + 32'((k % rows) * stride + (k / rows) * blk) : start + 32'(k * blk);
        exp_addr.push_back(a);
        for (int b = 0; b < beats; b++) exp_data.push_back(word_of(a, b));
      end
  endtask

  // Memory model and monitor: sample mid-cycle, apply after the edge.
  initial begin
    forever begin
      bit do_pop, do_hs;
      @(negedge clk);
      do_pop = rd_fifo_pop;
      do_hs  = mem_req && mem_ack;
      if (do_hs) begin
        logic [31:0] e;
        e = (exp_addr.size() != 0) ? exp_addr.pop_front() : 32'hDEAD_DEAD;
        check(mem_addr == e, "R2/R3 request address", mem_addr, e);
        check(mem_size == cfg_blk_code, "R2 size code", 32'(mem_size), 32'(cfg_blk_code));
        for (int b = 0; b < (cfg_blk_code == 0 ? 1 : (8 << cfg_blk_code) / 4); b++)
          memq.push_back(word_of(mem_addr, b));
        acks_left--;
      end
      if (out_valid && (out_ready || cfg_blk_code != 0)) begin
        logic [31:0] e;
        e = (exp_data.size() != 0) ? exp_data.pop_front() : 32'hBAD0_BAD0;
        check(out_data == e, "R11 output word order", out_data, e);
      end
      @(posedge clk);
      #1;
      cyc++;
      if (do_pop && memq.size() != 0) void'(memq.pop_front());
      rd_fifo_empty = (memq.size() == 0);
      rd_fifo_data  = (memq.size() != 0) ? memq[0] : '0;
      ack_allow     = (acks_left > 0) && (!ack_gap || cyc[0]);
      if (rdy_toggle) out_ready = ~out_ready;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain_wait(input string req);
    int t = 0;
    while ((exp_data.size() != 0 || memq.size() != 0 || out_valid) && t < 3000) begin
      tick(1);
      t++;
    end
    check(t < 3000, req, 32'(exp_data.size()), 0);
  endtask

  task automatic run_case(input logic [31:0] start, input int count, input int code, input bit loop,
                          input bit jmp, input logic [31:0] jw, input int nreq, input int acks,
                          input string req);
    int blk, beats;
    blk   = (code == 0) ? 4 : (8 << code);
    beats = blk / 4;
    cfg_start_addr = start; cfg_byte_count = 32'(count); cfg_blk_code = 4'(code);
    cfg_loop = loop; cfg_jump_en = jmp; cfg_jump_word = jw;
    push_expect(start, nreq, blk, beats, jmp, int'(jw[31:16]), int'(jw[15:0]) + 1, acks / nreq);
    acks_left = acks;
    cfg_run = 1'b1;
    tick(2);
    check(rd_done == 1'b0, "R5 done low while running", 32'(rd_done), 0);
    drain_wait(req);
    check(exp_addr.size() == 0, "R5 request count", 32'(exp_addr.size()), 0);
    check(rd_done == !loop, loop ? "R6 done stays low in loop" : "R5 done after last request",
          32'(rd_done), 32'(!loop));
    cfg_run = 1'b0;
    tick(2);
    check(mem_req == 1'b0, "R12 run low stops requests", 32'(mem_req), 0);
    acks_left = 0; rdy_toggle = 0; out_ready = 1'b1; ack_gap = 0;
    tick(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(rd_done == 1'b1, "R1 done after reset", 32'(rd_done), 1);
    check(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 0);
    check(out_valid == 1'b0, "R1 no valid after reset", 32'(out_valid), 0);

    // R7: jump word loaded but jump disabled; R8: ready toggles at code 0.
    rdy_toggle = 1;
    run_case(32'h1000, 24, 0, 0, 0, 32'h0123_0004, 6, 6, "R7 linear with jump ignored");

    // R3: transpose, stride 40, three rows, nine single-beat reads, gappy acks.
    ack_gap = 1;
    run_case(32'h2000, 36, 0, 0, 1, {16'd40, 16'd2}, 9, 9, "R3 transpose walk");

    // R5: count not a multiple of the block: 10 bytes -> 3 requests.
    run_case(32'h3000, 10, 0, 0, 0, 32'h0, 3, 3, "R5 partial count");

    // R9: 32-byte burst code with out_ready held low; ready is ignored.
    out_ready = 1'b0;
    run_case(32'h4000, 64, 2, 0, 0, 32'h0, 2, 2, "R9 burst ignores ready");

    // R6: looping transpose, 2 rows x 2 columns, three passes.
    run_case(32'h5000, 16, 0, 1, 1, {16'd16, 16'd1}, 4, 12, "R6 loop with column wrap");

    // R10/R8: holding register stalled, requests must stop and data hold.
    begin
      logic [31:0] held;
      cfg_start_addr = 32'h6000; cfg_byte_count = 12; cfg_blk_code = 0;
      cfg_loop = 0; cfg_jump_en = 0;
      push_expect(32'h6000, 3, 4, 1, 0, 0, 1, 1);
      acks_left = 3;
      out_ready = 1'b0;
      cfg_run = 1'b1;
      tick(10);
      check(out_valid == 1'b1, "R8 word offered", 32'(out_valid), 1);
      check(mem_req == 1'b0, "R10 no request while full", 32'(mem_req), 0);
      held = out_data;
      tick(3);
      check(out_data == held && out_valid, "R8 word held under stall", out_data, held);
      check(out_data == exp_data[0], "R11 held word is next", out_data, exp_data[0]);
      out_ready = 1'b1;
      drain_wait("R10 drain after stall");
      check(rd_done == 1'b1, "R5 done after stall case", 32'(rd_done), 1);
      cfg_run = 1'b0;
      tick(2);
    end

    // R12: run held high after completion does not restart.
    cfg_run = 1'b1; acks_left = 5;
    push_expect(32'h6000, 3, 4, 1, 0, 0, 1, 1);
    tick(1);
    drain_wait("R12 restart on rising edge");
    cfg_run = 1'b1;
    tick(6);
    check(mem_req == 1'b0 && rd_done, "R12 no restart while run stays high", 32'(mem_req), 0);
    cfg_run = 1'b0;
    acks_left = 0;
    tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule